// File: doc/BRIEF.md
# Interrupt Register Stacking Sequencer

This block saves the processor's programming registers to a byte-wide stack when an interrupt is taken and brings them back on return from interrupt. An entry pulse carries the index of the winning interrupt source. On that pulse the block captures the program counter, both index registers, both accumulators, the condition code byte and the stack pointer. It then writes nine bytes downward from the stack pointer, one per clock. Once the condition code byte is in memory it signals this, so that the mask flags can be set. Last, it reads the two-byte service address from the vector table and loads it into the program counter.

A return pulse runs the inverse. The stack pointer is pre-incremented before each of nine byte reads. The bytes come back in the reverse of the push order. When the last byte arrives, the block loads every restored register and the stack pointer at once. Memory reads are combinational: the byte on `mem_rdata` is taken at the clock edge that ends a read cycle.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we`, `mem_re`, `vec_req`, `ccr_stacked` and all load strobes are low.
- R2: An entry pulse accepted at clock edge E starts nine consecutive write cycles. Write cycle k (k = 0 to 8) puts address SP−k on `mem_addr`, where SP is `sp_in` as sampled at E. The bytes are written in this order: PC low, PC high, IY low, IY high, IX low, IX high, ACCA, ACCB, CCR. Input changes after E have no effect on the written bytes.
- R3: At the end of entry the block drives `sp_out` = SP−9 (modulo 2^16), with `sp_ld` high.
- R4: `ccr_stacked` is high for exactly one cycle: the cycle right after the CCR byte is written, which is also the first vector read cycle.
- R5: The vector table is read in two cycles with `vec_req` high. The address is VEC_BASE − 2·index. The high byte is read first at that address, and the low byte next at that address + 1. `pc_out` then equals {high, low}, with `ld_pc` high.
- R6: A return pulse starts nine consecutive read cycles at addresses SP+1 through SP+9. The bytes are taken as CCR, ACCB, ACCA, IX high, IX low, IY high, IY low, PC high, PC low. At completion all six register load strobes are high together with the rebuilt values.
- R7: At the end of return the block drives `sp_out` = SP+9 (modulo 2^16), with `sp_ld` high.
- R8: One byte moves per clock with no idle cycles. `busy` is high for 12 cycles on entry (9 writes, 2 vector reads, 1 load) and 10 cycles on return (9 reads, 1 load).
- R9: Entry and return pulses that arrive while `busy` is high are ignored, and the sequence in progress continues unchanged.
- R10: `done` is high for exactly one cycle, the last busy cycle, together with the load strobes. During entry completion only `ld_pc` of the register strobes is high.
- R11: If entry and return pulses arrive together while idle, the block runs entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req | input | 1 | Start interrupt entry |
| vec_idx | input | VIDX_W | Index of the winning interrupt source |
| return_req | input | 1 | Start return from interrupt |
| pc_in | input | 2·BYTE_W | Current program counter |
| iy_in | input | 2·BYTE_W | Current IY |
| ix_in | input | 2·BYTE_W | Current IX |
| acca_in | input | BYTE_W | Current ACCA |
| accb_in | input | BYTE_W | Current ACCB |
| ccr_in | input | BYTE_W | Current condition code byte |
| sp_in | input | 2·BYTE_W | Current stack pointer |
| mem_addr | output | 2·BYTE_W | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | BYTE_W | Byte being written |
| mem_rdata | input | BYTE_W | Byte read (combinational) |
| ccr_stacked | output | 1 | CCR byte has been stacked |
| vec_req | output | 1 | Vector fetch in progress |
| vec_addr | output | 2·BYTE_W | Vector table address of the source |
| ld_pc | output | 1 | Load program counter |
| ld_iy | output | 1 | Load IY |
| ld_ix | output | 1 | Load IX |
| ld_acca | output | 1 | Load ACCA |
| ld_accb | output | 1 | Load ACCB |
| ld_ccr | output | 1 | Load condition code byte |
| pc_out | output | 2·BYTE_W | New program counter |
| iy_out | output | 2·BYTE_W | Restored IY |
| ix_out | output | 2·BYTE_W | Restored IX |
| acca_out | output | BYTE_W | Restored ACCA |
| accb_out | output | BYTE_W | Restored ACCB |
| ccr_out | output | BYTE_W | Restored condition code byte |
| sp_out | output | 2·BYTE_W | Working stack pointer |
| sp_ld | output | 1 | Load stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completes this cycle |

## Verification
The assertions assume that `mem_rdata` is valid during every read cycle. They also assume that start pulses are synchronous single-cycle levels, and that entry and return pulses may overlap each other or fall inside a busy window. The bench drives each start for one cycle on the falling edge. It answers every read from a byte model of memory that it fills from observed writes, or from a computed pattern for the vector table. It deliberately raises both starts together, and raises them again in the middle of a push sequence, to exercise the ignore and priority rules. Stack pointers and vector indices are drawn at random, with directed cases at address wrap and at the largest index.

// File: rtl/irq_stk_pkg.sv
package irq_stk_pkg;
   localparam int FRAME_BYTES = 9;
   localparam int CNT_W       = $clog2(FRAME_BYTES);
   localparam int VEC_BYTES   = 2;

   // slot numbers follow push order; the byte lanes decode on them
   localparam int SLOT_PCL  = 0;
   localparam int SLOT_PCH  = 1;
   localparam int SLOT_IYL  = 2;
   localparam int SLOT_IYH  = 3;
   localparam int SLOT_IXL  = 4;
   localparam int SLOT_IXH  = 5;
   localparam int SLOT_ACCA = 6;
   localparam int SLOT_ACCB = 7;
   localparam int SLOT_CCR  = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH,
      ST_PULL,
      ST_VEC,
      ST_FIN
   } seq_st_e;
endpackage

// File: rtl/irq_stk_ctrl.sv
module irq_stk_ctrl
   import irq_stk_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             entry_req,
   input  logic             return_req,
   output seq_st_e          st,
   output logic [CNT_W-1:0] cnt,
   output logic             start_entry,
   output logic             start_return,
   output logic             ccr_stk
);
   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(FRAME_BYTES - 1);
   localparam logic [CNT_W-1:0] LAST_VEC  = CNT_W'(VEC_BYTES - 1);

   // entry wins over return when both arrive while idle
   assign start_entry  = (st == ST_IDLE) && entry_req;
   assign start_return = (st == ST_IDLE) && !entry_req && return_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         ccr_stk <= 1'b0;
      end else begin
         ccr_stk <= (st == ST_PUSH) && (cnt == LAST_BYTE);
         unique case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (start_entry)       st <= ST_PUSH;
               else if (start_return) st <= ST_PULL;
            end
            ST_PUSH: begin
               if (cnt == LAST_BYTE) begin
                  st  <= ST_VEC;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_VEC: begin
               if (cnt == LAST_VEC) begin
                  st  <= ST_FIN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PULL: begin
               if (cnt == LAST_BYTE) begin
                  st  <= ST_FIN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R9: a running sequence is never cut short by a new start
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && st != ST_FIN) |=> (st != ST_IDLE));

   // R8: one byte per clock, counter steps by one inside the push run
   a_r8_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PUSH && cnt != LAST_BYTE) |=> (st == ST_PUSH && cnt == $past(cnt) + 1'b1));

   // R10: the completion state lasts a single cycle
   a_r10_fin_once: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FIN) |=> (st == ST_IDLE));
endmodule

// File: rtl/irq_stk_sp.sv
module irq_stk_sp #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic              dec,
   input  logic              inc,
   output logic [ADDR_W-1:0] sp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp_q <= '0;
      else if (load) sp_q <= sp_in;
      else if (dec)  sp_q <= sp_q - 1'b1;
      else if (inc)  sp_q <= sp_q + 1'b1;
   end

   // R3: each push moves the pointer down by one
   a_r3_sp_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (sp_q == $past(sp_q) - 1'b1));

   // R7: each pull moves the pointer up by one
   a_r7_sp_pull_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && !dec) |=> (sp_q == $past(sp_q) + 1'b1));
endmodule

// File: rtl/irq_stk_frame.sv
module irq_stk_frame #(
   parameter int BYTE_W = 8,
   parameter int NSLOT  = 9,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_en,
   input  logic [BYTE_W-1:0] snap   [NSLOT],
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [BYTE_W-1:0] rd_byte,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [BYTE_W-1:0] wr_byte,
   output logic [BYTE_W-1:0] slots  [NSLOT]
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                slots[i] <= '0;
         else if (snap_en)                          slots[i] <= snap[i];
         else if (wr_en && wr_sel == SEL_W'(i))     slots[i] <= wr_byte;
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (rd_sel == SEL_W'(i)) rd_byte = slots[i];
      end
   end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
   import irq_stk_pkg::*;
#(
   parameter int          BYTE_W   = 8,
   parameter int          VIDX_W   = 5,
   parameter int unsigned VEC_BASE = 32'h0000_FFFE
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                entry_req,
   input  logic [VIDX_W-1:0]   vec_idx,
   input  logic                return_req,
   input  logic [2*BYTE_W-1:0] pc_in,
   input  logic [2*BYTE_W-1:0] iy_in,
   input  logic [2*BYTE_W-1:0] ix_in,
   input  logic [BYTE_W-1:0]   acca_in,
   input  logic [BYTE_W-1:0]   accb_in,
   input  logic [BYTE_W-1:0]   ccr_in,
   input  logic [2*BYTE_W-1:0] sp_in,
   output logic [2*BYTE_W-1:0] mem_addr,
   output logic                mem_we,
   output logic                mem_re,
   output logic [BYTE_W-1:0]   mem_wdata,
   input  logic [BYTE_W-1:0]   mem_rdata,
   output logic                ccr_stacked,
   output logic                vec_req,
   output logic [2*BYTE_W-1:0] vec_addr,
   output logic                ld_pc,
   output logic                ld_iy,
   output logic                ld_ix,
   output logic                ld_acca,
   output logic                ld_accb,
   output logic                ld_ccr,
   output logic [2*BYTE_W-1:0] pc_out,
   output logic [2*BYTE_W-1:0] iy_out,
   output logic [2*BYTE_W-1:0] ix_out,
   output logic [BYTE_W-1:0]   acca_out,
   output logic [BYTE_W-1:0]   accb_out,
   output logic [BYTE_W-1:0]   ccr_out,
   output logic [2*BYTE_W-1:0] sp_out,
   output logic                sp_ld,
   output logic                busy,
   output logic                done
);
   localparam int ADDR_W = 2 * BYTE_W;
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VEC_BASE);
   localparam logic [CNT_W-1:0]  LAST_BYTE = CNT_W'(FRAME_BYTES - 1);

   if (BYTE_W < 4) begin : g_bad_byte
      $error("irq_stack_seq: BYTE_W must be at least 4");
   end
   if (VIDX_W < 1 || VIDX_W >= ADDR_W) begin : g_bad_vidx
      $error("irq_stack_seq: VIDX_W must lie in 1..ADDR_W-1");
   end
   if (FRAME_BYTES >= (1 << CNT_W)) begin : g_bad_cnt
      $error("irq_stack_seq: counter too narrow for frame");
   end

   seq_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic             start_entry;
   logic             start_return;
   logic             ccr_stk;
   logic             ret_mode;
   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] vaddr_q;
   logic [BYTE_W-1:0] snap  [FRAME_BYTES];
   logic [BYTE_W-1:0] slots [FRAME_BYTES];
   logic [BYTE_W-1:0] push_byte;
   logic [CNT_W-1:0]  wr_sel;

   irq_stk_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .entry_req    (entry_req),
      .return_req   (return_req),
      .st           (st),
      .cnt          (cnt),
      .start_entry  (start_entry),
      .start_return (start_return),
      .ccr_stk      (ccr_stk)
   );

   irq_stk_sp #(.ADDR_W(ADDR_W)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_entry || start_return),
      .sp_in (sp_in),
      .dec   (st == ST_PUSH),
      .inc   (st == ST_PULL),
      .sp_q  (sp_q)
   );

   // snapshot lanes in push order
   always_comb begin
      snap[SLOT_PCL]  = pc_in[BYTE_W-1:0];
      snap[SLOT_PCH]  = pc_in[ADDR_W-1:BYTE_W];
      snap[SLOT_IYL]  = iy_in[BYTE_W-1:0];
      snap[SLOT_IYH]  = iy_in[ADDR_W-1:BYTE_W];
      snap[SLOT_IXL]  = ix_in[BYTE_W-1:0];
      snap[SLOT_IXH]  = ix_in[ADDR_W-1:BYTE_W];
      snap[SLOT_ACCA] = acca_in;
      snap[SLOT_ACCB] = accb_in;
      snap[SLOT_CCR]  = ccr_in;
   end

   // pulls fill slots from the top down; the vector fills PCH then PCL
   always_comb begin
      if (st == ST_VEC) wr_sel = CNT_W'(SLOT_PCH) - cnt;
      else              wr_sel = LAST_BYTE - cnt;
   end

   irq_stk_frame #(
      .BYTE_W (BYTE_W),
      .NSLOT  (FRAME_BYTES),
      .SEL_W  (CNT_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap_en (start_entry),
      .snap    (snap),
      .rd_sel  (cnt),
      .rd_byte (push_byte),
      .wr_en   (mem_re),
      .wr_sel  (wr_sel),
      .wr_byte (mem_rdata),
      .slots   (slots)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_mode <= 1'b0;
         vaddr_q  <= '0;
      end else if (start_entry) begin
         ret_mode <= 1'b0;
         vaddr_q  <= BASE - (ADDR_W'(vec_idx) << 1);
      end else if (start_return) begin
         ret_mode <= 1'b1;
      end
   end

   always_comb begin
      mem_we = (st == ST_PUSH);
      mem_re = (st == ST_PULL) || (st == ST_VEC);
      unique case (st)
         ST_PUSH: mem_addr = sp_q;
         ST_PULL: mem_addr = sp_q + 1'b1;
         ST_VEC:  mem_addr = vaddr_q + ADDR_W'(cnt);
         default: mem_addr = '0;
      endcase
   end

   assign mem_wdata   = mem_we ? push_byte : '0;
   assign vec_req     = (st == ST_VEC);
   assign vec_addr    = vaddr_q;
   assign ccr_stacked = ccr_stk;
   assign busy        = (st != ST_IDLE);
   assign done        = (st == ST_FIN);
   assign sp_ld       = done;
   assign sp_out      = sp_q;
   assign ld_pc       = done;
   assign ld_iy       = done && ret_mode;
   assign ld_ix       = done && ret_mode;
   assign ld_acca     = done && ret_mode;
   assign ld_accb     = done && ret_mode;
   assign ld_ccr      = done && ret_mode;

   assign pc_out   = {slots[SLOT_PCH], slots[SLOT_PCL]};
   assign iy_out   = {slots[SLOT_IYH], slots[SLOT_IYL]};
   assign ix_out   = {slots[SLOT_IXH], slots[SLOT_IXL]};
   assign acca_out = slots[SLOT_ACCA];
   assign accb_out = slots[SLOT_ACCB];
   assign ccr_out  = slots[SLOT_CCR];

   // R4: the stacked flag follows directly on a write and meets the vector fetch
   a_r4_ccr_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_stacked |-> (vec_req && $past(mem_we)));

   // R5: second vector byte sits one address above the first
   a_r5_vec_step: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req && $past(vec_req)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R2: consecutive writes walk down by one address
   a_r2_push_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));

   // R10: completion is a single-cycle pulse followed by idle
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R1: no memory traffic while idle
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re && !vec_req));
endmodule

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 8;
   localparam int VW = 5;
   localparam logic [15:0] VBASE = 16'hFFFE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic entry_req = 1'b0, return_req = 1'b0;
   logic [VW-1:0] vec_idx = '0;
   logic [15:0] pc_in = '0, iy_in = '0, ix_in = '0, sp_in = '0;
   logic [7:0] acca_in = '0, accb_in = '0, ccr_in = '0, mem_rdata = '0;
   logic [15:0] mem_addr, vec_addr, pc_out, iy_out, ix_out, sp_out;
   logic [7:0] mem_wdata, acca_out, accb_out, ccr_out;
   logic mem_we, mem_re, ccr_stacked, vec_req, ld_pc, ld_iy, ld_ix;
   logic ld_acca, ld_accb, ld_ccr, sp_ld, busy, done;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [7:0] mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_stack_seq #(.BYTE_W(BW), .VIDX_W(VW), .VEC_BASE(32'h0000_FFFE)) u_dut (
      .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .vec_idx(vec_idx),
      .return_req(return_req), .pc_in(pc_in), .iy_in(iy_in), .ix_in(ix_in),
      .acca_in(acca_in), .accb_in(accb_in), .ccr_in(ccr_in), .sp_in(sp_in),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .ccr_stacked(ccr_stacked), .vec_req(vec_req),
      .vec_addr(vec_addr), .ld_pc(ld_pc), .ld_iy(ld_iy), .ld_ix(ld_ix),
      .ld_acca(ld_acca), .ld_accb(ld_accb), .ld_ccr(ld_ccr), .pc_out(pc_out),
      .iy_out(iy_out), .ix_out(ix_out), .acca_out(acca_out), .accb_out(accb_out),
      .ccr_out(ccr_out), .sp_out(sp_out), .sp_ld(sp_ld), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] vbyte(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction

   function automatic logic [7:0] mrd(input logic [15:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return 8'h00;
   endfunction

   task automatic run_entry(input logic [15:0] pc, iy, ix, input logic [7:0] a, b, c,
                            input logic [15:0] sp, input logic [VW-1:0] idx,
                            input bit both, input bit poke);
      logic [7:0] exp_b [9];
      logic [15:0] va;
      exp_b = '{pc[7:0], pc[15:8], iy[7:0], iy[15:8], ix[7:0], ix[15:8], a, b, c};
      va = VBASE - {10'd0, idx, 1'b0};
      @(negedge clk);
      pc_in = pc; iy_in = iy; ix_in = ix; acca_in = a; accb_in = b; ccr_in = c;
      sp_in = sp; vec_idx = idx; entry_req = 1'b1; return_req = both;
      @(negedge clk);
      entry_req = 1'b0; return_req = 1'b0;
      pc_in = ~pc; iy_in = ~iy; ix_in = ~ix; acca_in = ~a; accb_in = ~b; ccr_in = ~c;
      sp_in = ~sp; vec_idx = ~idx;
      for (int k = 0; k < 9; k++) begin
         entry_req = 1'b0; return_req = 1'b0;
         chk(mem_we && !mem_re, both ? "R11" : "R2", "write strobe", {mem_we, mem_re}, 2);
         chk(mem_addr == sp - 16'(k), "R2", "push address", mem_addr, sp - 16'(k));
         chk(mem_wdata == exp_b[k], "R2", "push byte", mem_wdata, exp_b[k]);
         chk(!ccr_stacked && busy, "R4", "ccr flag early", ccr_stacked, 0);
         mem[int'(mem_addr)] = mem_wdata;
         if (poke && k == 3) begin
            entry_req = 1'b1; return_req = 1'b1;
         end
         @(negedge clk);
      end
      entry_req = 1'b0; return_req = 1'b0;
      for (int j = 0; j < 2; j++) begin
         chk(vec_req && mem_re && !mem_we, "R5", "vector read strobe", {vec_req, mem_re}, 3);
         chk(mem_addr == va + 16'(j), "R5", "vector address", mem_addr, va + 16'(j));
         chk(vec_addr == va, "R5", "vec_addr", vec_addr, va);
         chk(ccr_stacked == (j == 0), "R4", "ccr stacked timing", ccr_stacked, j == 0);
         mem_rdata = vbyte(mem_addr);
         @(negedge clk);
      end
      chk(done && busy && ld_pc && sp_ld, "R10", "completion strobes", {done, busy, ld_pc, sp_ld}, 15);
      chk(!ld_ccr && !ld_iy && !ld_ix && !ld_acca && !ld_accb, "R10", "only pc loaded on entry",
          {ld_ccr, ld_iy, ld_ix, ld_acca, ld_accb}, 0);
      chk(pc_out == {vbyte(va), vbyte(va + 16'd1)}, "R5", "vector pc", pc_out,
          {vbyte(va), vbyte(va + 16'd1)});
      chk(sp_out == sp - 16'd9, "R3", "sp after entry", sp_out, sp - 16'd9);
      @(negedge clk);
      chk(!busy && !done && !mem_we && !ccr_stacked, "R8", "idle after 12 cycles",
          {busy, done, mem_we, ccr_stacked}, 0);
   endtask

   task automatic run_return(input logic [15:0] sp);
      logic [15:0] e_pc, e_iy, e_ix;
      e_pc = {mrd(sp + 16'd8), mrd(sp + 16'd9)};
      e_iy = {mrd(sp + 16'd6), mrd(sp + 16'd7)};
      e_ix = {mrd(sp + 16'd4), mrd(sp + 16'd5)};
      @(negedge clk);
      sp_in = sp; return_req = 1'b1;
      @(negedge clk);
      return_req = 1'b0; sp_in = ~sp;
      for (int k = 0; k < 9; k++) begin
         chk(mem_re && !mem_we && !vec_req, "R6", "read strobe", {mem_re, mem_we, vec_req}, 4);
         chk(mem_addr == sp + 16'(k + 1), "R6", "pull address", mem_addr, sp + 16'(k + 1));
         mem_rdata = mrd(mem_addr);
         @(negedge clk);
      end
      chk(done && ld_pc && ld_iy && ld_ix && ld_acca && ld_accb && ld_ccr && sp_ld, "R10",
          "return strobes", done, 1);
      chk(ccr_out == mrd(sp + 16'd1), "R6", "ccr restored", ccr_out, mrd(sp + 16'd1));
      chk(accb_out == mrd(sp + 16'd2), "R6", "accb restored", accb_out, mrd(sp + 16'd2));
      chk(acca_out == mrd(sp + 16'd3), "R6", "acca restored", acca_out, mrd(sp + 16'd3));
      chk(ix_out == e_ix, "R6", "ix restored", ix_out, e_ix);
      chk(iy_out == e_iy, "R6", "iy restored", iy_out, e_iy);
      chk(pc_out == e_pc, "R6", "pc restored", pc_out, e_pc);
      chk(sp_out == sp + 16'd9, "R7", "sp after return", sp_out, sp + 16'd9);
      @(negedge clk);
      chk(!busy && !done, "R8", "idle after 10 cycles", {busy, done}, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !done && !mem_we && !mem_re && !vec_req && !ccr_stacked, "R1",
          "reset quiet", {busy, done, mem_we, mem_re, vec_req, ccr_stacked}, 0);
      chk(!ld_pc && !ld_ccr && !sp_ld, "R1", "reset strobes", {ld_pc, ld_ccr, sp_ld}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R1", "idle after release", busy, 0);

      run_entry(16'hC123, 16'h4567, 16'h89AB, 8'h11, 8'h22, 8'hD0, 16'h01FF, 5'd0, 1'b0, 1'b0);
      run_return(16'h01FF - 16'd9);
      // R3 wrap at low addresses, largest index, R9 poke mid-push
      run_entry(16'h0F0E, 16'h1D1C, 16'h2B2A, 8'h39, 8'h48, 8'h57, 16'h0004, 5'd31, 1'b0, 1'b1);
      run_return(16'h0004 - 16'd9);
      // R11 both starts together
      run_entry(16'hAAAA, 16'h5555, 16'h0F0F, 8'hF0, 8'h0F, 8'hC4, 16'h8000, 5'd7, 1'b1, 1'b0);
      run_return(16'h8000 - 16'd9);
      // random frames
      for (int it = 0; it < 8; it++) begin
         logic [15:0] rsp;
         rsp = 16'($urandom);
         run_entry(16'($urandom), 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                   8'($urandom), rsp, VW'($urandom), 1'($urandom), 1'($urandom));
         run_return(rsp - 16'd9);
      end
      // return over a frame never pushed by the block
      for (int it = 0; it < 3; it++) begin
         logic [15:0] rsp;
         rsp = 16'($urandom);
         for (int k = 1; k <= 9; k++) mem[int'(rsp + 16'(k))] = 8'($urandom);
         run_return(rsp);
      end
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule